// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a parameterised set of asynchronous external input lines and records a pending flag for each line whenever an enabled edge arrives. Every line has its own rising-edge enable, falling-edge enable, interrupt mask and event mask. When a line's flag is set and its interrupt mask bit is 1, the block drives a one-cycle pulse on that line's interrupt output. The flag stays latched until software clears it by writing a 1 to it.

Software reaches six 32-bit registers through a simple register bus with separate read and write strobes. The bus decodes a 0x400-byte window. Software can also raise any line's flag without an edge by writing the software-event register. A clock-domain crossing stage on every input turns each edge into exactly one detection. Reset is asynchronous active-low, and its release is synchronised to the clock inside the block.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all six registers read 0 and every interrupt output is 0.
- R2: When line n rises and rising-enable bit n is 1, pending bit n is set. When rising-enable bit n is 0, a rise leaves pending bit n at 0. The pending bit and the output pulse appear on the third rising clock edge after the input change is first sampled.
- R3: When line n falls and falling-enable bit n is 1, pending bit n is set. When both enable bits are 1, each edge sets the bit. A fall with falling-enable bit 0 does not set it.
- R4: A write to the pending register (offset 0x14) clears every bit written as 1 and leaves every bit written as 0 unchanged. No write ever sets a pending bit.
- R5: When interrupt-mask bit n is 0, output n never pulses. Pending bit n is still latched.
- R6: When mask bit n is 1, the output for line n is high for exactly one clock cycle per setting event. It is not a level held until the flag is cleared.
- R7: The register offsets are: interrupt mask 0x00, event mask 0x04, rising enable 0x08, falling enable 0x0C, software event 0x10, pending 0x14. The first five read back the last value written, restricted to the low NUM_LINES bits. Bits NUM_LINES..31 always read 0. Read data is registered and valid in the cycle after the read strobe.
- R8: A read of any other offset in the window, including an offset that is not word-aligned, returns 0. A write to such an offset changes no register.
- R9: Writing 1 to software-event bit n sets pending bit n in the next cycle. If mask bit n is 1, it also produces a one-cycle pulse on output n in that same cycle.
- R10: If a detected edge and a write clearing the same pending bit take effect on the same clock edge, the pending bit ends up set.
- R11: Each input edge sets the flag once. A level held high or low after the flag has been cleared does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | Asynchronous external input lines |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pulse_o | output | NUM_LINES | One-cycle interrupt pulse per line |

## Verification
The bench exercises both edge polarities, each on its own and then together on one line. It checks that a disabled polarity does not set the flag, which would catch a design that pends on any transition. It checks that the output stays silent on a masked line while the flag is still latched, and it measures the pulse width so that a design holding the output as a level fails. It times a clearing write to land on the same clock edge as a detected rise, so a design that lets the clear win loses the flag. It also confirms that a held level does not re-pend once the flag is cleared. Register-file checks cover readback trimming of the upper bits, unmapped and unaligned offsets, and writes of zero to the pending register, which a design that assigns instead of clearing would get wrong.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  localparam int unsigned REG_W = 32;

  // Byte offsets of the register window
  localparam logic [11:0] OFF_MASK  = 12'h000;
  localparam logic [11:0] OFF_EVTM  = 12'h004;
  localparam logic [11:0] OFF_RISE  = 12'h008;
  localparam logic [11:0] OFF_FALL  = 12'h00C;
  localparam logic [11:0] OFF_SWEV  = 12'h010;
  localparam logic [11:0] OFF_PEND  = 12'h014;

  typedef enum logic [2:0] {
    SEL_MASK,
    SEL_EVTM,
    SEL_RISE,
    SEL_FALL,
    SEL_SWEV,
    SEL_PEND,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/edge_irq_rst_sync.sv
module edge_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
  parameter int unsigned NUM_LINES  = 23,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);

  localparam int unsigned LAST = SYNC_DEPTH - 1;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      logic [SYNC_DEPTH-1:0] sync_q;
      logic [SYNC_DEPTH-1:0] sync_d;
      logic                  prev_q;
      logic                  prev_d;

      always_comb begin
        sync_d = {sync_q[SYNC_DEPTH-2:0], line_i[g]};
        prev_d = sync_q[LAST];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '0;
          prev_q <= 1'b0;
        end else begin
          sync_q <= sync_d;
          prev_q <= prev_d;
        end
      end

      assign rise_o[g] =  sync_q[LAST] & ~prev_q;
      assign fall_o[g] = ~sync_q[LAST] &  prev_q;
    end
  endgenerate

  // R3: a line cannot show both edges in one cycle
  p_rise_fall_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_o & fall_o) == '0));

  // R11: one edge is reported for a single cycle only
  p_edge_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((rise_o & $past(rise_o)) == '0) && ((fall_o & $past(fall_o)) == '0)));

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 23,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [REG_W-1:0]     bus_wdata,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic [NUM_LINES-1:0] fall_i,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [NUM_LINES-1:0] irq_o
);

  localparam int unsigned PAD_W = REG_W - NUM_LINES;

  reg_sel_e sel;

  logic [NUM_LINES-1:0] mask_q, mask_d;
  logic [NUM_LINES-1:0] evtm_q, evtm_d;
  logic [NUM_LINES-1:0] rise_en_q, rise_en_d;
  logic [NUM_LINES-1:0] fall_en_q, fall_en_d;
  logic [NUM_LINES-1:0] swev_q, swev_d;
  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] irq_q, irq_d;
  logic [REG_W-1:0]     rdata_q, rdata_d;

  logic [NUM_LINES-1:0] wbits;
  logic [NUM_LINES-1:0] sw_set;
  logic [NUM_LINES-1:0] hw_set;
  logic [NUM_LINES-1:0] set_vec;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] rd_field;

  logic en_mask, en_evtm, en_rise, en_fall, en_swev;

  // Address decode: full match only; anything else is unmapped
  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == OFF_MASK[ADDR_W-1:0]) sel = SEL_MASK;
    else if (bus_addr == OFF_EVTM[ADDR_W-1:0]) sel = SEL_EVTM;
    else if (bus_addr == OFF_RISE[ADDR_W-1:0]) sel = SEL_RISE;
    else if (bus_addr == OFF_FALL[ADDR_W-1:0]) sel = SEL_FALL;
    else if (bus_addr == OFF_SWEV[ADDR_W-1:0]) sel = SEL_SWEV;
    else if (bus_addr == OFF_PEND[ADDR_W-1:0]) sel = SEL_PEND;
  end

  // Write enables and next-state values of the configuration registers
  always_comb begin
    wbits   = bus_wdata[NUM_LINES-1:0];
    en_mask = bus_wr && (sel == SEL_MASK);
    en_evtm = bus_wr && (sel == SEL_EVTM);
    en_rise = bus_wr && (sel == SEL_RISE);
    en_fall = bus_wr && (sel == SEL_FALL);
    en_swev = bus_wr && (sel == SEL_SWEV);
    mask_d    = en_mask ? wbits : mask_q;
    evtm_d    = en_evtm ? wbits : evtm_q;
    rise_en_d = en_rise ? wbits : rise_en_q;
    fall_en_d = en_fall ? wbits : fall_en_q;
    swev_d    = en_swev ? wbits : swev_q;
  end

  // Pending flags: sets are applied after clears, so an edge beats a clear
  always_comb begin
    sw_set  = en_swev ? wbits : '0;
    clr_vec = (bus_wr && (sel == SEL_PEND)) ? wbits : '0;
    hw_set  = (rise_i & rise_en_q) | (fall_i & fall_en_q);
    set_vec = hw_set | sw_set;
    pend_d  = (pend_q & ~clr_vec) | set_vec;
    irq_d   = set_vec & mask_q;
  end

  // Read mux
  always_comb begin
    unique case (sel)
      SEL_MASK: rd_field = mask_q;
      SEL_EVTM: rd_field = evtm_q;
      SEL_RISE: rd_field = rise_en_q;
      SEL_FALL: rd_field = fall_en_q;
      SEL_SWEV: rd_field = swev_q;
      SEL_PEND: rd_field = pend_q;
      default:  rd_field = '0;
    endcase
    rdata_d = bus_rd ? {{PAD_W{1'b0}}, rd_field} : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      evtm_q    <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      swev_q    <= '0;
      pend_q    <= '0;
      irq_q     <= '0;
      rdata_q   <= '0;
    end else begin
      mask_q    <= mask_d;
      evtm_q    <= evtm_d;
      rise_en_q <= rise_en_d;
      fall_en_q <= fall_en_d;
      swev_q    <= swev_d;
      pend_q    <= pend_d;
      irq_q     <= irq_d;
      rdata_q   <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  // R4: a pending bit only rises when an edge or software event set it
  p_pend_rise_has_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

  // R5: a line masked in the previous cycle never pulses
  p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_q & ~$past(mask_q)) == '0));

  // R6: a pulse is always accompanied by its latched flag
  p_pulse_implies_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_q & ~pend_q) == '0));

  // R10: a bit that was being set is pending afterwards, whatever the clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~pend_q) == '0));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 23,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_pulse_o
);

  logic                 rst_n_sync;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] fall;

  edge_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  edge_irq_detect #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) u_det (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .line_i (line_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  edge_irq_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .rise_i    (rise),
    .fall_i    (fall),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_pulse_o)
  );

  generate
    if (NUM_LINES < 32) begin : g_pad_chk
      // R7: bits above the implemented lines always read zero
      p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (bus_rdata[31:NUM_LINES] == '0));
    end
  endgenerate

endmodule

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;

  localparam int unsigned NL = 23;
  localparam int unsigned AW = 10;
  localparam logic [31:0] LMASK = 32'h007F_FFFF;

  localparam logic [9:0] A_MASK = 10'h000;
  localparam logic [9:0] A_EVTM = 10'h004;
  localparam logic [9:0] A_RISE = 10'h008;
  localparam logic [9:0] A_FALL = 10'h00C;
  localparam logic [9:0] A_SWEV = 10'h010;
  localparam logic [9:0] A_PEND = 10'h014;

  // {is_write, req, addr, wdata, expected}
  localparam int NV = 23;
  localparam logic [78:0] VEC [0:NV-1] = '{
    {1'b1, 4'd7, A_EVTM, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd7, A_EVTM, 32'h0, 32'h007F_FFFF},
    {1'b1, 4'd7, A_EVTM, 32'h0001_2345, 32'h0},
    {1'b0, 4'd7, A_EVTM, 32'h0, 32'h0001_2345},
    {1'b1, 4'd7, A_RISE, 32'hAAAA_AAAA, 32'h0},
    {1'b0, 4'd7, A_RISE, 32'h0, 32'h002A_AAAA},
    {1'b1, 4'd7, A_FALL, 32'h5555_5555, 32'h0},
    {1'b0, 4'd7, A_FALL, 32'h0, 32'h0055_5555},
    {1'b1, 4'd7, A_MASK, 32'h0F0F_0F0F, 32'h0},
    {1'b0, 4'd7, A_MASK, 32'h0, 32'h000F_0F0F},
    {1'b1, 4'd8, 10'h018, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd8, 10'h018, 32'h0, 32'h0},
    {1'b0, 4'd8, 10'h3FC, 32'h0, 32'h0},
    {1'b1, 4'd8, 10'h002, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd8, 10'h002, 32'h0, 32'h0},
    {1'b0, 4'd8, A_MASK, 32'h0, 32'h000F_0F0F},
    {1'b1, 4'd7, A_SWEV, 32'h0, 32'h0},
    {1'b0, 4'd7, A_SWEV, 32'h0, 32'h0},
    {1'b0, 4'd8, A_PEND, 32'h0, 32'h0},
    {1'b1, 4'd7, A_MASK, 32'h0, 32'h0},
    {1'b1, 4'd7, A_RISE, 32'h0, 32'h0},
    {1'b1, 4'd7, A_FALL, 32'h0, 32'h0},
    {1'b1, 4'd7, A_EVTM, 32'h0, 32'h0}
  };

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] line_i;
  logic [AW-1:0] bus_addr;
  logic          bus_wr;
  logic          bus_rd;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_pulse_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  edge_irq_ctrl #(.NUM_LINES(NL), .ADDR_W(AW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_i      (line_i),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_pulse_o (irq_pulse_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic irq_now(input string req, input logic [31:0] exp);
    chk(req, {9'b0, irq_pulse_o}, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    logic [31:0] rd;
    int i;
    line_i    = '0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    rst_n     = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: reset state of every register and output
    irq_now("R1", 32'h0);
    bus_read(A_MASK, rd); chk("R1", rd, 32'h0);
    bus_read(A_EVTM, rd); chk("R1", rd, 32'h0);
    bus_read(A_RISE, rd); chk("R1", rd, 32'h0);
    bus_read(A_FALL, rd); chk("R1", rd, 32'h0);
    bus_read(A_SWEV, rd); chk("R1", rd, 32'h0);
    bus_read(A_PEND, rd); chk("R1", rd, 32'h0);

    // R7 / R8: vector table of register accesses
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][78]) begin
        bus_write(VEC[v][73:64], VEC[v][63:32]);
      end else begin
        bus_read(VEC[v][73:64], rd);
        chk($sformatf("R%0d vec %0d", VEC[v][77:74], v), rd, VEC[v][31:0]);
      end
    end

    // R2 + R6: rising edge on line 0, unmasked, one-cycle pulse
    bus_write(A_RISE, 32'h1);
    bus_write(A_MASK, 32'h1);
    line_i[0] = 1'b1;
    idle(2);
    irq_now("R2 early", 32'h0);
    idle(1);
    irq_now("R2 pulse", 32'h1);
    idle(1);
    irq_now("R6 width", 32'h0);
    bus_read(A_PEND, rd); chk("R2 pend", rd, 32'h1);
    bus_write(A_PEND, 32'h1);
    idle(5);
    // R11: held high level does not re-pend
    bus_read(A_PEND, rd); chk("R11", rd, 32'h0);
    // R3: fall without falling enable
    line_i[0] = 1'b0;
    idle(5);
    bus_read(A_PEND, rd); chk("R3 disabled fall", rd, 32'h0);
    // R2: rise on line 1 with its enable clear
    line_i[1] = 1'b1;
    idle(5);
    bus_read(A_PEND, rd); chk("R2 disabled rise", rd, 32'h0);

    // R3: falling edge on line 2
    bus_write(A_FALL, 32'h4);
    line_i[2] = 1'b1;
    idle(5);
    bus_read(A_PEND, rd); chk("R3 rise ignored", rd, 32'h0);
    line_i[2] = 1'b0;
    idle(5);
    bus_read(A_PEND, rd); chk("R3 fall", rd, 32'h4);
    bus_write(A_PEND, 32'h4);

    // R3: both edges on line 3
    bus_write(A_RISE, 32'h9);
    bus_write(A_FALL, 32'hC);
    line_i[3] = 1'b1;
    idle(5);
    bus_read(A_PEND, rd); chk("R3 both rise", rd, 32'h8);
    bus_write(A_PEND, 32'h8);
    line_i[3] = 1'b0;
    idle(5);
    bus_read(A_PEND, rd); chk("R3 both fall", rd, 32'h8);
    bus_write(A_PEND, 32'h8);

    // R5: masked line 4 latches but stays silent
    bus_write(A_RISE, 32'h10);
    bus_write(A_MASK, 32'h0);
    line_i[4] = 1'b1;
    for (i = 0; i < 6; i++) begin
      @(negedge clk);
      irq_now("R5 silent", 32'h0);
    end
    bus_read(A_PEND, rd); chk("R5 latched", rd, 32'h10);

    // R4: write of zeros leaves flags; write of ones clears only those
    bus_write(A_SWEV, 32'h200);
    bus_write(A_PEND, 32'h0);
    bus_read(A_PEND, rd); chk("R4 zero write", rd, 32'h210);
    bus_write(A_PEND, 32'h10);
    bus_read(A_PEND, rd); chk("R4 partial clear", rd, 32'h200);
    bus_write(A_PEND, 32'hFFFF_FFFF);
    bus_read(A_PEND, rd); chk("R4 full clear", rd, 32'h0);

    // R9: software event on unmasked line 5 and masked line 6
    bus_write(A_MASK, 32'h20);
    bus_addr  = A_SWEV;
    bus_wdata = 32'h60;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    irq_now("R9 pulse", 32'h20);
    @(negedge clk);
    irq_now("R9 width", 32'h0);
    bus_read(A_PEND, rd); chk("R9 pend", rd, 32'h60);
    bus_read(A_SWEV, rd); chk("R9 readback", rd, 32'h60);
    bus_write(A_PEND, 32'h60);

    // R10: edge and clearing write on the same clock edge
    bus_write(A_RISE, 32'h80);
    bus_write(A_SWEV, 32'h80);
    bus_read(A_PEND, rd); chk("R10 pre", rd, 32'h80);
    line_i[7] = 1'b1;
    idle(2);
    bus_write(A_PEND, 32'h80);
    bus_read(A_PEND, rd); chk("R10 edge wins", rd, 32'h80);

    // R1: reset in the middle of operation
    line_i = '0;
    idle(4);
    do_reset();
    irq_now("R1 mid", 32'h0);
    bus_read(A_PEND, rd); chk("R1 mid pend", rd, 32'h0);
    bus_read(A_RISE, rd); chk("R1 mid rise", rd, 32'h0);
    bus_read(A_MASK, rd); chk("R1 mid mask", rd, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule